// File: doc/BRIEF.md
# PLL Lock and Loop-Bandwidth Controller

This block is the digital supervisor that sits beside a clock PLL. It counts VCO edges over a window defined by a fixed number of reference ticks and compares the count with an expected value. From that frequency error it drives the loop-filter mode (acquisition or tracking) and a lock status. Each of these two indicators has its own enter and exit tolerances, so that a small amount of noise does not make it chatter. A byte-wide register interface lets software do four things: switch the PLL on, choose between automatic and manual bandwidth handling, route the VCO in as base clock, and enable an interrupt that fires whenever the lock status changes.

In automatic mode the hardware owns the filter-mode bit, and the lock bit and the interrupt are live. In manual mode software writes the filter-mode bit directly, lock reporting is forced off and no interrupt is raised. This suits systems that run well below their top bus frequency and want a fast start. The VCO edges and reference ticks arrive as single-cycle pulses that are already synchronous to `clk`.

Top module: `pll_bw_ctrl`

## Requirements
- R1: The frequency error is |N - EXP_COUNT|. N is the number of `vco_tick` pulses in the cycles after a window-start reference tick, up to and including the cycle of the REF_PER_WIN-th reference tick that follows it. That ending tick also starts the next window. After enable, the first reference tick only starts a window, so a partial window is never evaluated.
- R2: In automatic mode the filter-mode output sets after a window with error <= TRACK_ENTER and clears after a window with error > TRACK_EXIT. Otherwise it holds. A window takes effect two clock edges after the cycle of its ending tick.
- R3: In automatic mode the lock output sets after a window with error <= LOCK_ENTER and clears after a window with error > LOCK_EXIT. Otherwise it holds. It has the same latency as R2.
- R4: While automatic mode, PLL enable and interrupt enable are all set, every change of lock (rising or falling) sets a sticky interrupt flag (CTRL bit 7). Writing 1 to CTRL bit 7 clears the flag, and a new event in the same cycle wins over the clear. `irq` = flag AND interrupt enable AND automatic mode.
- R5: Register BW (address 1) holds the automatic-mode bit at bit 0 and the filter-mode bit at bit 1. With automatic mode clear, bit 1 is written by software and drives `filter_track` directly. A write to bit 1 is ignored if automatic mode was already set before that write.
- R6: With automatic mode clear, lock reads 0 and the interrupt flag is never set.
- R7: When PLL enable (CTRL bit 0) is 0, lock, the hardware filter mode and the window counters are held at 0.
- R8: The base-clock select (CTRL bit 2) drives `base_sel_vco`. A loss of lock while it is set still raises the interrupt of R4.
- R9: After reset all registers read 0. CTRL (address 0) reads {flag, 4'b0, select, irq enable, PLL enable}. BW reads {5'b0, lock, filter_track, auto}. Lock (BW bit 2) is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| vco_tick | input | 1 | One-cycle pulse per VCO edge (already synchronized) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = CTRL, 1 = BW |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| pll_on | output | 1 | PLL enable to the analog core |
| filter_track | output | 1 | Loop-filter mode: 1 = tracking, 0 = acquisition |
| base_sel_vco | output | 1 | Base clock select: 1 = VCO |
| lock | output | 1 | Lock status |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle that each hysteresis flag can only rise after a window whose error is within its enter tolerance, and can only fall after one beyond its exit tolerance or when forced clear. They also check that lock stays low in manual mode, that the interrupt flag only rises under automatic mode with interrupts enabled, and that the meter stays silent while disabled. The exact window boundaries are shown only by the bench scenarios, which compare against a cycle-level reference model through a sequence of VCO rates that walk the error across every band. The same scenarios cover the discarded partial window after enable, the ignored software write in automatic mode and the write-one-to-clear ordering.

// File: rtl/pll_bw_pkg.sv
package pll_bw_pkg;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_BW   = 1'b1;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SEL_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 7;
    localparam int BW_AUTO_BIT   = 0;
    localparam int BW_TRK_BIT    = 1;
    localparam int BW_LOCK_BIT   = 2;

    typedef struct packed {
        logic vco_sel;
        logic irq_en;
        logic pll_en;
    } ctrl_t;

    typedef struct packed {
        logic sw_track;
        logic auto_mode;
    } bw_t;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } meter_state_e;

    function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pll_freq_meter.sv
module pll_freq_meter
    import pll_bw_pkg::*;
#(
    parameter int EXP_COUNT   = 40,
    parameter int REF_PER_WIN = 4,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          ref_tick,
    input  logic          vco_tick,
    output logic          err_valid,
    output logic [CW-1:0] err
);
    localparam int RW = (REF_PER_WIN > 1) ? $clog2(REF_PER_WIN) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(REF_PER_WIN - 1);

    meter_state_e  state_q;
    logic [CW-1:0] vco_cnt_q;
    logic [RW-1:0] ref_cnt_q;
    logic [CW:0]   sum;
    logic [CW-1:0] cnt_sat;
    logic          win_end;

    always_comb begin
        sum     = {1'b0, vco_cnt_q} + (CW+1)'(vco_tick);
        cnt_sat = sum[CW] ? '1 : sum[CW-1:0];
        win_end = (state_q == MS_RUN) && ref_tick && (ref_cnt_q == REF_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q   <= MS_IDLE;
            vco_cnt_q <= '0;
            ref_cnt_q <= '0;
            err_valid <= 1'b0;
            err       <= '0;
        end else begin
            err_valid <= 1'b0;
            case (state_q)
                MS_IDLE: begin
                    if (ref_tick) begin
                        state_q   <= MS_RUN;
                        vco_cnt_q <= '0;
                        ref_cnt_q <= '0;
                    end
                end
                default: begin
                    if (win_end) begin
                        err_valid <= 1'b1;
                        err       <= CW'(abs_diff(int'(cnt_sat), EXP_COUNT));
                        vco_cnt_q <= '0;
                        ref_cnt_q <= '0;
                    end else begin
                        vco_cnt_q <= cnt_sat;
                        if (ref_tick) ref_cnt_q <= ref_cnt_q + RW'(1);
                    end
                end
            endcase
        end
    end

    // R7: a disabled meter produces no result
    assert_meter_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !err_valid);

endmodule

// File: rtl/pll_hyst_flag.sv
module pll_hyst_flag #(
    parameter int CW    = 8,
    parameter int ENTER = 2,
    parameter int EXIT  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          upd,
    input  logic [CW-1:0] err,
    output logic          flag,
    output logic          flag_nxt
);
    always_comb begin
        flag_nxt = flag;
        if (clear)                     flag_nxt = 1'b0;
        else if (upd && err <= CW'(ENTER)) flag_nxt = 1'b1;
        else if (upd && err >  CW'(EXIT))  flag_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= flag_nxt;
    end

    // R2 R3: entry only from an in-tolerance window
    assert_rise_in_tol_R2_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(upd) && ($past(err) <= CW'(ENTER))));

    // R2 R3 R7: exit only on forced clear or a window beyond the exit tolerance
    assert_fall_out_tol_R2_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(clear) || ($past(upd) && ($past(err) > CW'(EXIT)))));

endmodule

// File: rtl/pll_bw_ctrl.sv
module pll_bw_ctrl
    import pll_bw_pkg::*;
#(
    parameter int EXP_COUNT   = 40,
    parameter int REF_PER_WIN = 4,
    parameter int LOCK_ENTER  = 2,
    parameter int LOCK_EXIT   = 6,
    parameter int TRACK_ENTER = 4,
    parameter int TRACK_EXIT  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       vco_tick,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       pll_on,
    output logic       filter_track,
    output logic       base_sel_vco,
    output logic       lock,
    output logic       irq
);
    localparam int CW = $clog2(4 * EXP_COUNT);

    ctrl_t         ctrl_q;
    bw_t           bw_q;
    logic          flag_q;
    logic          wr_ctrl, wr_bw, status_clear;
    logic          err_valid;
    logic [CW-1:0] err;
    logic          lock_nxt, hw_track, hw_track_nxt;
    logic          lock_event;

    assign wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_bw        = wr_en && (wr_addr == ADDR_BW);
    assign status_clear = !ctrl_q.pll_en || !bw_q.auto_mode;
    assign lock_event   = (lock_nxt != lock) && ctrl_q.pll_en && bw_q.auto_mode && ctrl_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            bw_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.pll_en  <= wr_data[CTRL_EN_BIT];
                ctrl_q.irq_en  <= wr_data[CTRL_IE_BIT];
                ctrl_q.vco_sel <= wr_data[CTRL_SEL_BIT];
            end
            if (wr_bw) begin
                bw_q.auto_mode <= wr_data[BW_AUTO_BIT];
                if (!bw_q.auto_mode) bw_q.sw_track <= wr_data[BW_TRK_BIT];
            end
            if (lock_event)
                flag_q <= 1'b1;
            else if (wr_ctrl && wr_data[CTRL_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    pll_freq_meter #(
        .EXP_COUNT  (EXP_COUNT),
        .REF_PER_WIN(REF_PER_WIN),
        .CW         (CW)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl_q.pll_en),
        .ref_tick (ref_tick),
        .vco_tick (vco_tick),
        .err_valid(err_valid),
        .err      (err)
    );

    pll_hyst_flag #(.CW(CW), .ENTER(LOCK_ENTER), .EXIT(LOCK_EXIT)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .clear   (status_clear),
        .upd     (err_valid),
        .err     (err),
        .flag    (lock),
        .flag_nxt(lock_nxt)
    );

    pll_hyst_flag #(.CW(CW), .ENTER(TRACK_ENTER), .EXIT(TRACK_EXIT)) u_track (
        .clk     (clk),
        .rst     (rst),
        .clear   (status_clear),
        .upd     (err_valid),
        .err     (err),
        .flag    (hw_track),
        .flag_nxt(hw_track_nxt)
    );

    assign pll_on       = ctrl_q.pll_en;
    assign base_sel_vco = ctrl_q.vco_sel;
    assign filter_track = bw_q.auto_mode ? hw_track : bw_q.sw_track;
    assign irq          = flag_q && ctrl_q.irq_en && bw_q.auto_mode;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[CTRL_EN_BIT]   = ctrl_q.pll_en;
            rd_data[CTRL_IE_BIT]   = ctrl_q.irq_en;
            rd_data[CTRL_SEL_BIT]  = ctrl_q.vco_sel;
            rd_data[CTRL_FLAG_BIT] = flag_q;
        end else begin
            rd_data[BW_AUTO_BIT] = bw_q.auto_mode;
            rd_data[BW_TRK_BIT]  = filter_track;
            rd_data[BW_LOCK_BIT] = lock;
        end
    end

    // R6: manual mode forces lock low on the following edge
    assert_manual_no_lock_R6: assert property (@(posedge clk) disable iff (rst)
        !bw_q.auto_mode |=> !lock);

    // R4 R6: flag only rises with automatic mode, PLL and interrupts enabled
    assert_flag_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(bw_q.auto_mode && ctrl_q.irq_en && ctrl_q.pll_en));

    // R7: lock cannot be set while the PLL is off
    assert_off_no_lock_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.pll_en |=> !lock);

endmodule

// File: tb/tb_pll_bw_ctrl.sv
`timescale 1ns/1ps
module tb_pll_bw_ctrl;
    localparam int EXP = 40;
    localparam int REFS = 4;
    localparam int L_IN = 2, L_OUT = 6, T_IN = 4, T_OUT = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0, vco_tick = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic pll_on, filter_track, base_sel_vco, lock, irq;

    int checks = 0, errors = 0;
    int cyc = 0;
    int vco_n = 40;
    bit running = 1'b0;

    always #4 clk = ~clk;

    pll_bw_ctrl dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pll_on(pll_on),
        .filter_track(filter_track), .base_sel_vco(base_sel_vco),
        .lock(lock), .irq(irq)
    );

    // stimulus: ref tick every 16 cycles, vco_n ticks in each 64-cycle span
    always @(negedge clk) begin
        cyc <= cyc + 1;
        ref_tick <= ((cyc + 1) % 16 == 0);
        vco_tick <= (((cyc + 1) % 64) < vco_n);
    end

    // behavioural reference model
    int m_en, m_ie, m_sel, m_auto, m_sw, m_flag, m_lock, m_htrk;
    int armed, vc, rc, p_valid, p_err;
    always @(posedge clk) begin
        int o_en, o_ie, o_auto, nl, nt, np, ne;
        if (rst) begin
            m_en = 0; m_ie = 0; m_sel = 0; m_auto = 0; m_sw = 0; m_flag = 0;
            m_lock = 0; m_htrk = 0; armed = 0; vc = 0; rc = 0; p_valid = 0; p_err = 0;
        end else begin
            o_en = m_en; o_ie = m_ie; o_auto = m_auto;
            nl = m_lock; nt = m_htrk;
            if (!o_en || !o_auto) begin nl = 0; nt = 0; end
            else if (p_valid) begin
                if (p_err <= L_IN) nl = 1; else if (p_err > L_OUT) nl = 0;
                if (p_err <= T_IN) nt = 1; else if (p_err > T_OUT) nt = 0;
            end
            if (nl != m_lock && o_en && o_auto && o_ie) m_flag = 1;
            else if (wr_en && wr_addr == 1'b0 && wr_data[7]) m_flag = 0;
            m_lock = nl; m_htrk = nt;
            np = 0; ne = 0;
            if (!o_en) begin armed = 0; vc = 0; rc = 0; end
            else if (!armed) begin
                if (ref_tick) begin armed = 1; vc = 0; rc = 0; end
            end else if (ref_tick && rc == REFS - 1) begin
                ne = vc + int'(vco_tick);
                ne = (ne > EXP) ? ne - EXP : EXP - ne;
                np = 1; vc = 0; rc = 0;
            end else begin
                vc = vc + int'(vco_tick);
                if (ref_tick) rc = rc + 1;
            end
            p_valid = np; p_err = ne;
            if (wr_en && wr_addr == 1'b0) begin
                m_en = wr_data[0]; m_ie = wr_data[1]; m_sel = wr_data[2];
            end
            if (wr_en && wr_addr == 1'b1) begin
                if (!o_auto) m_sw = wr_data[1];
                m_auto = wr_data[0];
            end
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (running) begin
            int e_trk, e_irq;
            e_trk = m_auto ? m_htrk : m_sw;
            e_irq = m_flag & m_ie & m_auto;
            checks++;
            if (lock !== m_lock[0]) begin
                errors++; $display("FAIL R3 cycle %0d lock actual=%0b expected=%0d", cyc, lock, m_lock);
            end else if (filter_track !== e_trk[0]) begin
                errors++; $display("FAIL R2 cycle %0d filter_track actual=%0b expected=%0d", cyc, filter_track, e_trk);
            end else if (irq !== e_irq[0]) begin
                errors++; $display("FAIL R4 cycle %0d irq actual=%0b expected=%0d", cyc, irq, e_irq);
            end else if (pll_on !== m_en[0] || base_sel_vco !== m_sel[0]) begin
                errors++; $display("FAIL R8 cycle %0d pll_on/sel actual=%0b%0b expected=%0d%0d",
                                   cyc, pll_on, base_sel_vco, m_en, m_sel);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input string req, input logic [7:0] exp_v);
        @(negedge clk); rd_addr = a; #1;
        chk(req, rd_data, exp_v);
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_c(3);
        rst = 1'b0;
        // R9 reset state
        rd(1'b0, "R9 ctrl reset", 8'h00);
        rd(1'b1, "R9 bw reset", 8'h00);
        running = 1'b1;

        // R1 R2 R3 R4: acquire with zero error
        vco_n = 40;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h03);
        wait_c(60);
        chk("R1 no lock before full window", {7'b0, lock}, 8'h00);
        wait_c(160);
        rd(1'b1, "R3 R2 locked and tracking", 8'h07);
        chk("R4 irq on lock rise", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h83);
        chk("R4 w1c clears flag", {7'b0, irq}, 8'h00);

        // R8: lose lock with VCO selected
        wr(1'b0, 8'h87);
        vco_n = 48;
        wait_c(200);
        chk("R8 base select", {7'b0, base_sel_vco}, 8'h01);
        rd(1'b1, "R3 lock lost, still tracking", 8'h03);
        chk("R8 irq on lock loss", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h87);

        // R2: leave tracking, then re-enter in the band between tolerances
        vco_n = 55;
        wait_c(200);
        rd(1'b1, "R2 untracked", 8'h01);
        vco_n = 43;
        wait_c(200);
        rd(1'b1, "R2 R3 track entered, lock not", 8'h03);
        vco_n = 40;
        wait_c(200);
        vco_n = 45;
        wait_c(200);
        rd(1'b1, "R3 hysteresis holds lock", 8'h07);

        // R6 R5: manual mode
        wr(1'b0, 8'h87);
        wr(1'b1, 8'h00);
        wait_c(2);
        rd(1'b1, "R6 manual lock off", 8'h00);
        vco_n = 60;
        wait_c(200);
        vco_n = 40;
        wait_c(200);
        chk("R6 no irq in manual", {7'b0, irq}, 8'h00);
        rd(1'b0, "R6 flag stays clear", 8'h07);
        wr(1'b1, 8'h02);
        rd(1'b1, "R5 software track", 8'h02);
        wr(1'b1, 8'h00);
        rd(1'b1, "R5 software acquire", 8'h00);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h03);
        wr(1'b1, 8'h00);
        rd(1'b1, "R5 write in auto ignored", 8'h00);

        // R7: disable while locked
        wr(1'b1, 8'h01);
        wait_c(250);
        rd(1'b1, "R7 relocked before disable", 8'h07);
        wr(1'b0, 8'h86);
        wait_c(2);
        rd(1'b1, "R7 disable clears status", 8'h01);
        wait_c(100);
        rd(1'b1, "R7 stays clear while off", 8'h01);
        wr(1'b0, 8'h03);
        wait_c(250);
        rd(1'b1, "R1 relock after enable", 8'h07);

        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule